// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block works out data-memory addresses for the load, store, push and pop operations of a small 8-bit processor. It owns three 16-bit indirect pointers (X, Y, Z) and a stack pointer. When an operation begins, the block takes a decoded addressing mode, a pointer choice, a 6-bit unsigned offset and a 16-bit absolute address. It then drives a one-cycle read or write strobe with the address. After that it commits any pointer change and reports the new pointer value on a write-back port.

Each accepted operation occupies exactly two clock cycles. A request that names a combination the block does not support raises a one-cycle illegal flag, and no access is made. A side port lets the surrounding register file load any pointer. The register file, memory and decoder lie outside this block.

Top module: `ptr_agu`

## Requirements
- R1: After reset, X, Y and Z read as 0 and the stack pointer reads as SP_RESET (default 0x015F). While reset is held and afterwards until an operation is accepted, mem_rd, mem_wr, illegal, wb_valid and busy are 0.
- R2: Mode code 0 (plain) addresses the selected pointer (ptr_sel 0=X, 1=Y, 2=Z) and leaves it unchanged. mem_wr pulses when is_store=1 and mem_rd pulses when is_store=0. The two strobes are never high together.
- R3: Mode code 1 (post-increment) addresses the selected pointer's old value, and the pointer then becomes old+1 modulo 2^16.
- R4: Mode code 2 (pre-decrement) addresses old-1 modulo 2^16, and the pointer becomes that same value.
- R5: Mode code 3 (offset) addresses Y or Z plus the unsigned 6-bit disp (0..63), modulo 2^16, and does not change the pointer.
- R6: Offset mode with ptr_sel=0 (X), any indirect mode with ptr_sel=3, and mode code 7 each raise illegal for one cycle with no strobe, no busy and no pointer change.
- R7: Mode code 4 (direct) drives direct_addr unchanged as the address, whatever ptr_sel is.
- R8: Mode code 5 (push) writes at the stack pointer, which then drops by 1. Mode code 6 (pop) raises the stack pointer by 1 and reads at the raised value. Both ignore is_store.
- R9: A start seen while idle gives a strobe and busy in the next cycle only. busy then falls, so each operation takes two cycles. A start seen while busy is ignored.
- R10: ptr_wr_en loads ptr_wr_data into the pointer named by ptr_wr_sel (3 = stack pointer) at the clock edge. A pointer update that completes at the same edge takes priority over it.
- R11: In the cycle after an updating access (modes 1, 2, 5, 6), wb_valid is 1, wb_sel names the pointer (3 = stack pointer) and wb_value is its new value. wb_valid stays 0 for the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer choice: 0=X, 1=Y, 2=Z |
| is_store | input | 1 | 1 = write, 0 = read (modes 0-4) |
| disp | input | 6 | Unsigned offset for mode 3 |
| direct_addr | input | 16 | Absolute address for mode 4 |
| ptr_wr_en | input | 1 | Load a pointer from outside |
| ptr_wr_sel | input | 2 | Pointer to load, 3 = stack pointer |
| ptr_wr_data | input | 16 | Value to load |
| mem_addr | output | 16 | Memory address, valid while a strobe is high |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| busy | output | 1 | Operation in progress |
| illegal | output | 1 | Unsupported request rejected |
| wb_valid | output | 1 | Pointer changed this cycle |
| wb_sel | output | 2 | Which pointer changed |
| wb_value | output | 16 | New pointer value |

## Verification
After the edge that accepts a start, the strobe, address and busy are due one cycle later. The illegal flag for a rejected request also appears one cycle after that edge. The pointer write-back and the changed pointer are due one cycle after the strobe. The bench keeps a behavioural model that works on those same edges: it takes a snapshot of the pointers at the accepting edge and holds the pending update for one edge. It compares every output at each falling clock edge. The address is compared only while a strobe is high, and the write-back data only while wb_valid is high.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
   typedef enum logic [2:0] {
      AM_PLAIN   = 3'd0,
      AM_POSTINC = 3'd1,
      AM_PREDEC  = 3'd2,
      AM_OFFSET  = 3'd3,
      AM_DIRECT  = 3'd4,
      AM_PUSH    = 3'd5,
      AM_POP     = 3'd6,
      AM_RSVD    = 3'd7
   } agu_mode_e;

   typedef enum logic [1:0] {
      PS_X  = 2'd0,
      PS_Y  = 2'd1,
      PS_Z  = 2'd2,
      PS_SP = 2'd3
   } ptr_id_e;

   localparam int unsigned NUM_PTR = 4;
endpackage

// File: rtl/ptr_agu_bank.sv
module ptr_agu_bank
   import ptr_agu_pkg::*;
#(
   parameter int unsigned   AW       = 16,
   parameter logic [AW-1:0] SP_RESET = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ext_we,
   input  logic [1:0]                   ext_sel,
   input  logic [AW-1:0]                ext_data,
   input  logic                         upd_we,
   input  logic [1:0]                   upd_sel,
   input  logic [AW-1:0]                upd_data,
   output logic [NUM_PTR-1:0][AW-1:0]   ptr_q
);
   for (genvar i = 0; i < int'(NUM_PTR); i++) begin : g_ptr
      localparam logic [AW-1:0] RST_VAL = (i == int'(PS_SP)) ? SP_RESET : '0;
      always_ff @(posedge clk) begin
         if (!rst_n)
            ptr_q[i] <= RST_VAL;
         else if (upd_we && upd_sel == 2'(i))
            ptr_q[i] <= upd_data;
         else if (ext_we && ext_sel == 2'(i))
            ptr_q[i] <= ext_data;
      end
   end

   AST_UPD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      upd_we |=> ptr_q[$past(upd_sel)] == $past(upd_data)); // R10
endmodule

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc
   import ptr_agu_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned QW = 6
) (
   input  agu_mode_e                   mode,
   input  ptr_id_e                     sel,
   input  logic                        is_store,
   input  logic [QW-1:0]               disp,
   input  logic [AW-1:0]               direct_addr,
   input  logic [NUM_PTR-1:0][AW-1:0]  ptr_q,
   output logic [AW-1:0]               addr,
   output logic                        do_rd,
   output logic                        do_wr,
   output logic                        upd,
   output logic [1:0]                  upd_sel,
   output logic [AW-1:0]               upd_val,
   output logic                        bad
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] base, sp, qext;
   logic          wr_dir;

   assign base = ptr_q[sel];
   assign sp   = ptr_q[PS_SP];
   assign qext = AW'(disp);

   always_comb begin
      addr    = base;
      wr_dir  = is_store;
      upd     = 1'b0;
      upd_sel = sel;
      upd_val = base;
      bad     = 1'b0;
      unique case (mode)
         AM_PLAIN:   bad = (sel == PS_SP);
         AM_POSTINC: begin
            bad     = (sel == PS_SP);
            upd     = 1'b1;
            upd_val = base + ONE;
         end
         AM_PREDEC: begin
            bad     = (sel == PS_SP);
            addr    = base - ONE;
            upd     = 1'b1;
            upd_val = base - ONE;
         end
         AM_OFFSET: begin
            bad  = (sel == PS_X) || (sel == PS_SP);
            addr = base + qext;
         end
         AM_DIRECT:  addr = direct_addr;
         AM_PUSH: begin
            addr    = sp;
            wr_dir  = 1'b1;
            upd     = 1'b1;
            upd_sel = PS_SP;
            upd_val = sp - ONE;
         end
         AM_POP: begin
            addr    = sp + ONE;
            wr_dir  = 1'b0;
            upd     = 1'b1;
            upd_sel = PS_SP;
            upd_val = sp + ONE;
         end
         default:    bad = 1'b1;
      endcase
      do_wr = !bad && wr_dir;
      do_rd = !bad && !wr_dir;
   end
endmodule

// File: rtl/ptr_agu_seq.sv
module ptr_agu_seq #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] c_addr,
   input  logic          c_rd,
   input  logic          c_wr,
   input  logic          c_upd,
   input  logic [1:0]    c_upd_sel,
   input  logic [AW-1:0] c_upd_val,
   input  logic          c_bad,
   output logic          busy,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          illegal,
   output logic          wb_valid,
   output logic [1:0]    wb_sel,
   output logic [AW-1:0] wb_value,
   output logic          upd_we,
   output logic [1:0]    upd_sel,
   output logic [AW-1:0] upd_data
);
   logic          pend_upd;
   logic [1:0]    pend_sel;
   logic [AW-1:0] pend_val;

   assign upd_we   = busy && pend_upd;
   assign upd_sel  = pend_sel;
   assign upd_data = pend_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mem_addr <= '0;
         mem_rd   <= 1'b0;
         mem_wr   <= 1'b0;
         illegal  <= 1'b0;
         wb_valid <= 1'b0;
         wb_sel   <= '0;
         wb_value <= '0;
         pend_upd <= 1'b0;
         pend_sel <= '0;
         pend_val <= '0;
      end else begin
         mem_rd   <= 1'b0;
         mem_wr   <= 1'b0;
         illegal  <= 1'b0;
         wb_valid <= 1'b0;
         if (busy) begin
            busy     <= 1'b0;
            wb_valid <= pend_upd;
            wb_sel   <= pend_sel;
            wb_value <= pend_val;
         end else if (start) begin
            if (c_bad) begin
               illegal <= 1'b1;
            end else begin
               busy     <= 1'b1;
               mem_addr <= c_addr;
               mem_rd   <= c_rd;
               mem_wr   <= c_wr;
               pend_upd <= c_upd;
               pend_sel <= c_upd_sel;
               pend_val <= c_upd_val;
            end
         end
      end
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R2
   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |=> !(mem_rd || mem_wr)); // R9
   AST_BUSY_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy); // R9
   AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> busy); // R9
   AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_rd && !mem_wr && !busy)); // R6
   AST_WB_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(mem_rd || mem_wr)); // R11
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
   import ptr_agu_pkg::*;
#(
   parameter int unsigned   AW       = 16,
   parameter int unsigned   QW       = 6,
   parameter logic [AW-1:0] SP_RESET = AW'(16'h015F)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    mode,
   input  logic [1:0]    ptr_sel,
   input  logic          is_store,
   input  logic [QW-1:0] disp,
   input  logic [AW-1:0] direct_addr,
   input  logic          ptr_wr_en,
   input  logic [1:0]    ptr_wr_sel,
   input  logic [AW-1:0] ptr_wr_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          busy,
   output logic          illegal,
   output logic          wb_valid,
   output logic [1:0]    wb_sel,
   output logic [AW-1:0] wb_value
);
   initial begin : elab_chk
      assert (AW >= 8) else $error("ptr_agu: AW must be at least 8");
      assert (QW >= 1 && QW < AW) else $error("ptr_agu: QW must be in 1..AW-1");
   end

   logic [NUM_PTR-1:0][AW-1:0] ptr_q;
   logic [AW-1:0] c_addr, c_upd_val, upd_data;
   logic          c_rd, c_wr, c_upd, c_bad, upd_we;
   logic [1:0]    c_upd_sel, upd_sel;

   ptr_agu_bank #(.AW(AW), .SP_RESET(SP_RESET)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .ext_we(ptr_wr_en), .ext_sel(ptr_wr_sel), .ext_data(ptr_wr_data),
      .upd_we(upd_we), .upd_sel(upd_sel), .upd_data(upd_data),
      .ptr_q(ptr_q)
   );

   ptr_agu_calc #(.AW(AW), .QW(QW)) u_calc (
      .mode(agu_mode_e'(mode)), .sel(ptr_id_e'(ptr_sel)), .is_store(is_store),
      .disp(disp), .direct_addr(direct_addr), .ptr_q(ptr_q),
      .addr(c_addr), .do_rd(c_rd), .do_wr(c_wr), .upd(c_upd),
      .upd_sel(c_upd_sel), .upd_val(c_upd_val), .bad(c_bad)
   );

   ptr_agu_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .c_addr(c_addr), .c_rd(c_rd), .c_wr(c_wr), .c_upd(c_upd),
      .c_upd_sel(c_upd_sel), .c_upd_val(c_upd_val), .c_bad(c_bad),
      .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .illegal(illegal), .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_value(wb_value),
      .upd_we(upd_we), .upd_sel(upd_sel), .upd_data(upd_data)
   );

   AST_WB_MATCHES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ptr_q[wb_sel] == wb_value); // R11
endmodule

// File: tb/ptr_agu_bench.sv
module ptr_agu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  ptr_sel = '0;
   logic        is_store = 1'b0;
   logic [5:0]  disp = '0;
   logic [15:0] direct_addr = '0;
   logic        ptr_wr_en = 1'b0;
   logic [1:0]  ptr_wr_sel = '0;
   logic [15:0] ptr_wr_data = '0;
   logic [15:0] mem_addr, wb_value;
   logic        mem_rd, mem_wr, busy, illegal, wb_valid;
   logic [1:0]  wb_sel;

   always #5 clk = ~clk;

   ptr_agu u_ptr_agu (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ptr_sel(ptr_sel),
      .is_store(is_store), .disp(disp), .direct_addr(direct_addr),
      .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy),
      .illegal(illegal), .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_value(wb_value)
   );

   int    n_cmp = 0, n_bad = 0, cyc = 0;
   bit    done = 0;

   // behavioural reference model
   int    mp[4];
   bit    ext_seen[4];
   bit    mbusy, m_rd, m_wr, m_ill, m_wbv, p_upd;
   int    m_addr, m_wbs, m_wbval, p_sel, p_val;
   string m_tag = "R1", p_tag = "R1";

   always @(posedge clk) begin
      int  snap[4];
      bit  was_busy;
      if (!rst_n) begin
         mp = '{0, 0, 0, 'h15F};
         ext_seen = '{0, 0, 0, 0};
         mbusy = 0; m_rd = 0; m_wr = 0; m_ill = 0; m_wbv = 0; p_upd = 0;
         m_tag = "R1";
      end else begin
         snap = mp;
         was_busy = mbusy;
         m_rd = 0; m_wr = 0; m_ill = 0; m_wbv = 0;
         if (ptr_wr_en) begin  // R10 outside load, overridden by an update below
            mp[ptr_wr_sel] = ptr_wr_data;
            ext_seen[ptr_wr_sel] = 1;
         end
         if (was_busy) begin
            mbusy = 0;
            m_tag = p_tag;
            if (p_upd) begin
               mp[p_sel] = p_val;
               m_wbv = 1; m_wbs = p_sel; m_wbval = p_val;
            end
         end else if (start) begin
            int a, s, uv, us;
            bit bad, wr, up;
            string tg;
            s = ptr_sel; a = snap[s]; bad = 0; wr = is_store; up = 0; us = s; uv = a;
            case (mode)
               0: begin bad = (s == 3); tg = "R2"; end
               1: begin bad = (s == 3); up = 1; uv = (a + 1) & 'hFFFF; tg = "R3"; end
               2: begin bad = (s == 3); a = (a - 1) & 'hFFFF; up = 1; uv = a; tg = "R4"; end
               3: begin bad = (s == 0 || s == 3); a = (a + disp) & 'hFFFF; tg = "R5"; end
               4: begin a = direct_addr; tg = "R7"; end
               5: begin a = snap[3]; wr = 1; up = 1; us = 3; uv = (a - 1) & 'hFFFF; tg = "R8"; end
               6: begin a = (snap[3] + 1) & 'hFFFF; wr = 0; up = 1; us = 3; uv = a; tg = "R8"; end
               default: begin bad = 1; tg = "R6"; end
            endcase
            if (mode <= 3 && ext_seen[s]) tg = {tg, "/R10"};
            if (bad) begin
               m_ill = 1; m_tag = "R6";
            end else begin
               mbusy = 1; m_addr = a; m_rd = !wr; m_wr = wr;
               p_upd = up; p_sel = us; p_val = uv;
               m_tag = tg; p_tag = up ? {tg, "/R11"} : {tg, "/R9"};
            end
         end else begin
            m_tag = "R9";
         end
         if (start && was_busy) m_tag = "R9";
      end
   end

   task automatic chk(string nm, string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", tag, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      string tg;
      tg = rst_n ? m_tag : "R1";
      chk("mem_rd", tg, int'(mem_rd), rst_n ? int'(m_rd) : 0);
      chk("mem_wr", tg, int'(mem_wr), rst_n ? int'(m_wr) : 0);
      chk("busy", tg, int'(busy), rst_n ? int'(mbusy) : 0);
      chk("illegal", tg, int'(illegal), rst_n ? int'(m_ill) : 0);
      chk("wb_valid", tg, int'(wb_valid), rst_n ? int'(m_wbv) : 0);
      if (rst_n && (m_rd || m_wr)) chk("mem_addr", tg, int'(mem_addr), m_addr);
      if (rst_n && m_wbv) begin
         chk("wb_sel", tg, int'(wb_sel), m_wbs);
         chk("wb_value", tg, int'(wb_value), m_wbval);
      end
   end

   task automatic issue(int m, int s, bit st, int q, int k);
      @(negedge clk);
      mode = 3'(m); ptr_sel = 2'(s); is_store = st; disp = 6'(q); direct_addr = 16'(k);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
   endtask

   task automatic load_ptr(int s, int v);  // R10
      @(negedge clk);
      ptr_wr_en = 1'b1; ptr_wr_sel = 2'(s); ptr_wr_data = 16'(v);
      @(negedge clk);
      ptr_wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);          // R1 reset state compared
      rst_n = 1'b1;
      @(negedge clk);
      issue(0, 0, 0, 0, 0);               // R1 X reads 0
      issue(0, 2, 0, 0, 0);               // R1 Z reads 0
      issue(5, 0, 0, 0, 0);               // R1/R8 push at SP_RESET
      load_ptr(0, 'h1000);
      load_ptr(1, 'hFFF0);
      load_ptr(2, 'h0200);
      issue(0, 0, 0, 0, 0);               // R2 plain read
      issue(0, 1, 1, 0, 0);               // R2 plain write
      issue(1, 0, 0, 0, 0);               // R3
      issue(1, 0, 1, 0, 0);               // R3
      issue(2, 0, 0, 0, 0);               // R4
      issue(0, 0, 0, 0, 0);
      load_ptr(0, 'hFFFF);
      issue(1, 0, 0, 0, 0);               // R3 wrap to 0
      issue(2, 0, 1, 0, 0);               // R4 wrap to FFFF
      issue(3, 1, 0, 63, 0);              // R5 wrap
      issue(3, 2, 0, 0, 0);               // R5 zero offset
      issue(3, 2, 1, 5, 0);               // R5 store
      issue(3, 0, 0, 7, 0);               // R6 offset on X
      issue(0, 3, 0, 0, 0);               // R6 sel 3
      issue(7, 1, 0, 0, 0);               // R6 reserved mode
      issue(0, 0, 0, 0, 0);               // R6 X unchanged
      issue(4, 0, 1, 0, 'hBEEF);          // R7
      issue(4, 3, 0, 0, 'h0000);          // R7 sel ignored
      issue(5, 0, 0, 0, 0);               // R8 push ignores is_store
      issue(5, 0, 1, 0, 0);
      issue(6, 0, 1, 0, 0);               // R8 pop
      issue(6, 0, 0, 0, 0);
      // R9 start held across busy: second request ignored
      @(negedge clk);
      mode = 3'd1; ptr_sel = 2'd2; start = 1'b1;
      repeat (6) @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      // R10 outside load of Z at the edge its update completes: update wins
      @(negedge clk);
      mode = 3'd1; ptr_sel = 2'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ptr_wr_en = 1'b1; ptr_wr_sel = 2'd2; ptr_wr_data = 16'h7777;
      @(negedge clk);
      ptr_wr_en = 1'b0;
      issue(0, 2, 0, 0, 0);
      load_ptr(3, 'h0000);
      issue(5, 0, 0, 0, 0);               // R8 SP wrap on push
      issue(6, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule